// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block takes configuration words from a three-wire serial port: a data line, a serial clock and a load-enable strobe. Each rising edge of the serial clock shifts one data bit into a 22-bit shift register, most significant bit first. When load-enable rises, the two bits that arrived last act as an address. The 20 bits shifted in before them are copied into the one of four destination latches that the address names.

The serial lines are asynchronous to the host logic. All three pass through two-flop synchronisers into the system clock domain, and their edges are found there. Each latch has a strobe that is high for one system clock cycle when the latch takes a new word. The other three latches keep their contents.

Top module: `serial_word_loader`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released, all four latches read zero and no strobe is high until the first load.
- R2: Each rising edge of ser_clk shifts ser_data in, most significant bit first. The word keeps the 22 most recent bits. Word bits 21..2 are the payload and bits 1..0 (the last two shifted in) are the latch address.
- R3: A rising edge on ser_load writes the payload into latch_q[address], where address is the value 0..3 of the last two bits.
- R4: A load leaves the three latches it does not address unchanged.
- R5: The strobe latch_stb[address] is high for exactly one system cycle per load. It rises in the same cycle the latch value changes. At most one strobe is high at a time.
- R6: When more than 22 serial clocks arrive before a load, only the last 22 bits take effect.
- R7: Serial clocks with no ser_load rising edge change no latch and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, sampled on ser_clk rising edges |
| ser_load | input | 1 | Load-enable; a rising edge transfers the word |
| latch_q | output | 4x20 | The four destination latches, index = address |
| latch_stb | output | 4 | One-cycle write strobe per latch |

## Verification
A fault in the shift register shows up as a wrong payload or a wrong destination at the next load. For example, a slip of one bit would move a payload bit into the address field. The bench compares all four latches after every load, so such a fault is reported within one transferred word. Faults in the edge detection show up as missing, doubled or stretched strobes. A per-latch strobe count and a width count catch these at the same check. Shifting without a load and over-long words test whether the latches and the retained bits stay put when they should.

// File: rtl/serial_word_loader.sv
module serial_word_loader #(
  parameter int WORD_W = 22,
  parameter int ADDR_W = 2,
  localparam int PAY_W = WORD_W - ADDR_W,
  localparam int NLATCH = 1 << ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ser_clk,
  input  logic                          ser_data,
  input  logic                          ser_load,
  output logic [NLATCH-1:0][PAY_W-1:0]  latch_q,
  output logic [NLATCH-1:0]             latch_stb
);

  logic [2:0] clk_sr, dat_sr, le_sr;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sr <= '0;
      dat_sr <= '0;
      le_sr  <= '0;
    end else begin
      clk_sr <= {clk_sr[1:0], ser_clk};
      dat_sr <= {dat_sr[1:0], ser_data};
      le_sr  <= {le_sr[1:0], ser_load};
    end
  end

  wire sclk_rise = clk_sr[1] & ~clk_sr[2];
  wire load_rise = le_sr[1] & ~le_sr[2];
  wire [ADDR_W-1:0] addr = shreg[ADDR_W-1:0];
  wire [PAY_W-1:0] payload = shreg[WORD_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else if (sclk_rise) shreg <= {shreg[WORD_W-2:0], dat_sr[1]};
  end

  for (genvar i = 0; i < NLATCH; i++) begin : g_latch
    wire hit = load_rise && (addr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        latch_q[i]   <= '0;
        latch_stb[i] <= 1'b0;
      end else begin
        latch_stb[i] <= hit;
        if (hit) latch_q[i] <= payload;
      end
    end
  end

endmodule

// File: rtl/loader_checks.sv
module loader_checks #(
  parameter int WORD_W = 22,
  parameter int ADDR_W = 2,
  localparam int PAY_W = WORD_W - ADDR_W,
  localparam int NLATCH = 1 << ADDR_W
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         ser_load,
  input logic [NLATCH-1:0][PAY_W-1:0] latch_q,
  input logic [NLATCH-1:0]            latch_stb
);

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(latch_stb)); // R5

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|latch_stb) |=> !(|latch_stb)); // R5

  AST_WRITE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (|latch_stb) |-> ($past(ser_load, 3) && !$past(ser_load, 4))); // R3

  for (genvar i = 0; i < NLATCH; i++) begin : g_hold
    AST_HOLD_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_stb[i] |-> $stable(latch_q[i])); // R4
  end

endmodule

bind serial_word_loader loader_checks #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_serial_word_loader.sv
module sim_serial_word_loader;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_data = 0, ser_load = 0;
  logic [3:0][19:0] latch_q;
  logic [3:0] latch_stb;

  serial_word_loader u0 (.*);

  always #2.5 clk = ~clk;

  int pass_cnt = 0, fail_cnt = 0;
  int stb_cnt [4];
  int exp_cnt [4];
  int wide_cnt = 0, multi_cnt = 0;
  logic [3:0] stb_prev = '0;
  logic [19:0] model [4];
  bit done = 0;

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (latch_stb[i]) stb_cnt[i]++;
      if (latch_stb[i] && stb_prev[i]) wide_cnt++;
    end
    if ($countones(latch_stb) > 1) multi_cnt++;
    stb_prev <= latch_stb;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    if (ok) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  endtask

  task automatic shift_bits(input logic [63:0] v, input int n);
    for (int b = n - 1; b >= 0; b--) begin
      ser_data = v[b];
      #60 ser_clk = 1;
      #60 ser_clk = 0;
    end
    #60;
  endtask

  task automatic pulse_load();
    ser_load = 1;
    #60 ser_load = 0;
    #60;
  endtask

  task automatic check_all(input string req);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(latch_q[i] == model[i], req, 32'(latch_q[i]), 32'(model[i]));
      chk(stb_cnt[i] == exp_cnt[i], "R5 strobe count", stb_cnt[i], exp_cnt[i]);
    end
    chk(wide_cnt == 0, "R5 strobe width", wide_cnt, 0);
    chk(multi_cnt == 0, "R5 onehot", multi_cnt, 0);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      fail_cnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      model[i] = '0;
      stb_cnt[i] = 0;
      exp_cnt[i] = 0;
    end
    repeat (5) @(negedge clk);
    check_all("R1 during reset");
    rst_n = 1;
    repeat (10) @(negedge clk);
    check_all("R1 after reset");

    // R2 R3 R4: sweep all addresses over computed payloads
    for (int k = 0; k < 16; k++) begin
      for (int a = 0; a < 4; a++) begin
        logic [19:0] p;
        if (k == 0) p = '0;
        else if (k == 1) p = '1;
        else if (k < 7) p = 20'(1) << (k * 4 - 5);
        else p = 20'((k * 32'h2D37 + a * 32'h11111) ^ (k << 13));
        shift_bits({42'd0, p, 2'(a)}, 22);
        pulse_load();
        model[a] = p;
        exp_cnt[a]++;
        check_all("R3 R4 sweep");
      end
    end

    // R6: longer words keep only the final 22 bits
    for (int a = 0; a < 4; a++) begin
      logic [19:0] p;
      p = 20'(32'h5A5A5 + a * 32'h3C3C);
      shift_bits({34'h2ABCDEF3, p, 2'(a)}, 22 + 8 + a * 3);
      pulse_load();
      model[a] = p;
      exp_cnt[a]++;
      check_all("R6 overlong word");
    end

    // R7: shifting without load leaves every latch alone
    shift_bits({42'd0, 20'hFFFFF, 2'd1}, 22);
    repeat (20) @(negedge clk);
    check_all("R7 shift without load");
    shift_bits({42'd0, 20'h00F0F, 2'd2}, 22);
    check_all("R7 second shift without load");
    pulse_load();
    model[2] = 20'h00F0F;
    exp_cnt[2]++;
    check_all("R2 R3 load after idle shifts");

    done = 1;
    summary();
  end
endmodule